// File: doc/BRIEF.md
# CD Sector Sync Framer and Descrambler

This block takes the byte stream recovered from a CD player, one byte per valid cycle with an error flag from the player's second decoding stage, and cuts it into 2352-byte sectors. A sliding 12-byte comparator finds the sync field (00h, ten bytes of FFh, 00h). Bytes enter a 12-byte window, so the first sync byte leaves the window in the same cycle that the last sync byte arrives. Every sector byte, sync field included, is written in arrival order to buffer memory as a 9-bit word: the error flag sits above the data byte. An 8-bit memory can simply ignore bit 8.

Once locked, a flywheel counter expects the next sync exactly 2352 bytes after the previous one. If interpolation is enabled and the pattern does not appear there, a sync is inserted. A pattern that appears anywhere else is flagged and ignored. Detection and interpolation have separate enables. Bytes 12 to 2351 can pass through a descrambler. Status bits report how the current sector was entered. Writing can stop at once, or finish the sector in progress and stop at the next sync.

Top module: `cd_sector_framer`

## Requirements
- R1: With `detectEn`=1, the byte 00h arriving after 00h followed by ten FFh acquires lock. Each locked sector byte is then written once, in arrival order, to consecutive addresses. Addresses start at 0 after reset and wrap at 16 bits. `memData` bit 8 is the byte's `inErr` and bits 7:0 are the data. `memWe` rises one cycle after the input cycle in which the byte leaves the 12-byte window, which is 11 valid inputs after the byte arrived.
- R2: A sector is 2352 bytes (indices 0 to 2351, index 0 is the first sync byte). `sectorDone` is a one-cycle pulse in the cycle after index 2351 is written. In that same cycle `sectorStart` takes the address of index 0 of that sector. No pulse is given for a sector whose bytes were not all written.
- R3: When `descrambleEn`=1, bytes 12 to 2351 are XORed with a key from a 15-bit LFSR (x^15 + x + 1) that is preset to 0001h for byte 12. Key bit n, for n from 0 to 7, is the LFSR's bit 0. After each bit the LFSR shifts right and its bit 14 takes the old bit 0 XOR the old bit 1. Bytes 0 to 11 are never altered. When `descrambleEn`=0, all bytes are written unchanged.
- R4: When locked with `interpEn`=1 and no pattern ends at index 0 of the next sector, a sync is inserted there. Writing continues without a gap, and `noSync` is set.
- R5: When locked with `interpEn`=1, a pattern that ends at any other index sets `illegalSync` and changes neither the sector position nor the written data.
- R6: When locked with `interpEn`=0, a pattern that ends at an index other than 0 starts a new sector at that point (written at the next address) and sets `shortBlock`.
- R7: When locked with `interpEn`=0 and no pattern ends at index 0, lock is lost and `longBlock` is set. Nothing is written until a pattern is found again.
- R8: With `detectEn`=0, the block never acquires lock from the unlocked state, so nothing is written.
- R9: Dropping `bufferEn` mid-sector while `drainEn`=1 lets the current sector complete (all bytes written, `sectorDone` given). Writing stops at the next sector start.
- R10: Dropping `bufferEn` mid-sector with `drainEn`=0 stops writes from that input cycle on. No `sectorDone` is given for that sector.
- R11: After reset, all status bits, `memWe`, `sectorDone` and `sectorStart` are 0. At each sector start or loss of lock, `noSync`, `shortBlock` and `longBlock` are reloaded, with at most one of them set, and `illegalSync` is cleared. `illegalSync` stays set until the next such event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte valid this cycle |
| inByte | input | 8 | Incoming byte |
| inErr | input | 1 | Error flag of the incoming byte |
| detectEn | input | 1 | Enable sync pattern detection |
| interpEn | input | 1 | Enable flywheel sync insertion |
| descrambleEn | input | 1 | Enable descrambling of bytes 12..2351 |
| bufferEn | input | 1 | Write sectors to memory |
| drainEn | input | 1 | Finish the current sector when bufferEn drops |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | 16 | Memory write address |
| memData | output | 9 | {error flag, byte} |
| sectorDone | output | 1 | One-cycle pulse after a sector's last byte |
| sectorStart | output | 16 | Start address of the last completed sector |
| noSync | output | 1 | Current sector began with an inserted sync |
| illegalSync | output | 1 | Pattern seen at an unexpected position |
| shortBlock | output | 1 | Previous sector was cut short by an early sync |
| longBlock | output | 1 | Expected sync missing, lock lost |

## Verification
Clean back-to-back sectors, with descrambling on and off, pin down the write order, the error-flag placement, the LFSR key and the sector start addresses. Corrupting one sync byte tells the flywheel path (insertion with `noSync`) apart from the detect-only path (lock loss with `longBlock`). A pattern embedded inside the data separates the two mid-sector paths: with interpolation on it is ignored and flagged, and with interpolation off a truncated sector followed by a full one forces a resync with `shortBlock`. Toggling `bufferEn` at a fixed byte, with and without `drainEn`, shows whether a sector drains or stops at once, counted write by write.

// File: rtl/cdf_pkg.sv
package cdf_pkg;
  localparam int BYTE_W = 8;
  localparam int LFSR_W = 15;

  typedef struct packed {
    logic we;        // write the outgoing byte
    logic startSec;  // outgoing byte is index 0
    logic descr;     // apply descramble key
    logic lfsrLoad;  // preset LFSR for next byte
    logic lfsrStep;  // advance LFSR by one byte
    logic last;      // outgoing byte is final index
  } frStrobe_t;

  function automatic logic [BYTE_W-1:0] scrKey(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] r;
    logic [BYTE_W-1:0] k;
    r = s;
    k = '0;
    for (int b = 0; b < BYTE_W; b++) begin
      k[b] = r[0];
      r = {r[0] ^ r[1], r[LFSR_W-1:1]};
    end
    return k;
  endfunction

  function automatic logic [LFSR_W-1:0] scrNext(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] r;
    r = s;
    for (int b = 0; b < BYTE_W; b++) r = {r[0] ^ r[1], r[LFSR_W-1:1]};
    return r;
  endfunction
endpackage

// File: rtl/cdf_datapath.sv
module cdf_datapath
  import cdf_pkg::*;
#(
  parameter int SYNC_LEN = 12,
  parameter int ADDR_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [BYTE_W-1:0]   inByte,
  input  logic                inErr,
  input  frStrobe_t           stb,
  output logic                syncHit,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [BYTE_W:0]     memData,
  output logic                sectorDone,
  output logic [ADDR_W-1:0]   sectorStart
);
  localparam int WIN = SYNC_LEN - 1;

  logic [WIN-1:0][BYTE_W-1:0] winQ;
  logic [WIN-1:0]             errQ;
  logic [WIN-1:0]             posOk;
  logic [LFSR_W-1:0]          lfsrQ;
  logic [ADDR_W-1:0]          wrAddr;
  logic [ADDR_W-1:0]          curStart;
  logic                       lastQ;
  logic [BYTE_W-1:0]          outByte;
  logic                       outErr;

  // window compare: oldest stored byte must be 00h, the rest FFh
  for (genvar k = 0; k < WIN; k++) begin : g_cmp
    if (k == WIN - 1) begin : g_head
      assign posOk[k] = (winQ[k] == 8'h00);
    end else begin : g_body
      assign posOk[k] = (winQ[k] == 8'hFF);
    end
  end

  assign syncHit = inValid && (inByte == 8'h00) && (&posOk);
  assign outByte = winQ[WIN-1];
  assign outErr  = errQ[WIN-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winQ <= '0;
      errQ <= '0;
    end else if (inValid) begin
      winQ <= {winQ[WIN-2:0], inByte};
      errQ <= {errQ[WIN-2:0], inErr};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrQ <= LFSR_W'(1);
    end else if (stb.lfsrLoad) begin
      lfsrQ <= LFSR_W'(1);
    end else if (stb.lfsrStep) begin
      lfsrQ <= scrNext(lfsrQ);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWe       <= 1'b0;
      memAddr     <= '0;
      memData     <= '0;
      wrAddr      <= '0;
      curStart    <= '0;
      lastQ       <= 1'b0;
      sectorDone  <= 1'b0;
      sectorStart <= '0;
    end else begin
      memWe      <= stb.we;
      lastQ      <= stb.we && stb.last;
      sectorDone <= lastQ;
      if (lastQ) sectorStart <= curStart;
      if (stb.we) begin
        memAddr <= wrAddr;
        memData <= {outErr, stb.descr ? (outByte ^ scrKey(lfsrQ)) : outByte};
        wrAddr  <= wrAddr + 1'b1;
        if (stb.startSec) curStart <= wrAddr;
      end
    end
  end
endmodule

// File: rtl/cdf_control.sv
module cdf_control
  import cdf_pkg::*;
#(
  parameter int SECTOR_BYTES = 2352,
  parameter int SYNC_LEN     = 12
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      syncHit,
  input  logic      detectEn,
  input  logic      interpEn,
  input  logic      descrambleEn,
  input  logic      bufferEn,
  input  logic      drainEn,
  output frStrobe_t stb,
  output logic      noSync,
  output logic      illegalSync,
  output logic      shortBlock,
  output logic      longBlock
);
  localparam int IDX_W = $clog2(SECTOR_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SECTOR_BYTES - 1);
  localparam logic [IDX_W-1:0] SYNC_IDX = IDX_W'(SYNC_LEN - 1);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(SYNC_LEN);

  logic             lockedQ;
  logic             activeQ;
  logic [IDX_W-1:0] idxQ;

  logic hit, startEv, loseEv, illegalEv, shortEv, insertEv, proceed, writeOk;
  logic [IDX_W-1:0] curIdx;

  assign hit = syncHit && detectEn;

  always_comb begin
    startEv   = 1'b0;
    loseEv    = 1'b0;
    illegalEv = 1'b0;
    shortEv   = 1'b0;
    insertEv  = 1'b0;
    if (inValid) begin
      if (!lockedQ) begin
        startEv = hit;
      end else if (idxQ == '0) begin
        if (hit) begin
          startEv = 1'b1;
        end else if (interpEn) begin
          startEv  = 1'b1;
          insertEv = 1'b1;
        end else begin
          loseEv = 1'b1;
        end
      end else if (hit) begin
        if (interpEn) begin
          illegalEv = 1'b1;
        end else begin
          startEv = 1'b1;
          shortEv = 1'b1;
        end
      end
    end
  end

  assign curIdx  = startEv ? '0 : idxQ;
  assign proceed = inValid && (startEv || (lockedQ && !loseEv));
  assign writeOk = startEv ? bufferEn : (activeQ && (bufferEn || drainEn));

  always_comb begin
    stb          = '0;
    stb.we       = proceed && writeOk;
    stb.startSec = startEv;
    stb.last     = (curIdx == LAST_IDX);
    stb.descr    = descrambleEn && (curIdx >= DATA_IDX);
    stb.lfsrLoad = proceed && (curIdx == SYNC_IDX);
    stb.lfsrStep = proceed && (curIdx >= DATA_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockedQ <= 1'b0;
      activeQ <= 1'b0;
      idxQ    <= '0;
    end else begin
      if (loseEv) begin
        lockedQ <= 1'b0;
        activeQ <= 1'b0;
        idxQ    <= '0;
      end else if (proceed) begin
        lockedQ <= 1'b1;
        idxQ    <= (curIdx == LAST_IDX) ? '0 : curIdx + 1'b1;
        if (startEv) activeQ <= bufferEn;
        else if (!(bufferEn || drainEn)) activeQ <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      noSync      <= 1'b0;
      illegalSync <= 1'b0;
      shortBlock  <= 1'b0;
      longBlock   <= 1'b0;
    end else if (startEv || loseEv) begin
      noSync      <= insertEv;
      shortBlock  <= shortEv;
      longBlock   <= loseEv;
      illegalSync <= 1'b0;
    end else if (illegalEv) begin
      illegalSync <= 1'b1;
    end
  end
endmodule

// File: rtl/cd_sector_framer.sv
module cd_sector_framer
  import cdf_pkg::*;
#(
  parameter int SECTOR_BYTES = 2352,
  parameter int SYNC_LEN     = 12,
  parameter int ADDR_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [7:0]        inByte,
  input  logic              inErr,
  input  logic              detectEn,
  input  logic              interpEn,
  input  logic              descrambleEn,
  input  logic              bufferEn,
  input  logic              drainEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [8:0]        memData,
  output logic              sectorDone,
  output logic [ADDR_W-1:0] sectorStart,
  output logic              noSync,
  output logic              illegalSync,
  output logic              shortBlock,
  output logic              longBlock
);
  frStrobe_t stb;
  logic      syncHit;

  cdf_control #(.SECTOR_BYTES(SECTOR_BYTES), .SYNC_LEN(SYNC_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .syncHit(syncHit),
    .detectEn(detectEn), .interpEn(interpEn), .descrambleEn(descrambleEn),
    .bufferEn(bufferEn), .drainEn(drainEn), .stb(stb),
    .noSync(noSync), .illegalSync(illegalSync),
    .shortBlock(shortBlock), .longBlock(longBlock)
  );

  cdf_datapath #(.SYNC_LEN(SYNC_LEN), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte), .inErr(inErr),
    .stb(stb), .syncHit(syncHit), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .sectorDone(sectorDone), .sectorStart(sectorStart)
  );
endmodule

// File: rtl/cdf_checker.sv
module cdf_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              bufferEn,
  input logic              drainEn,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              sectorDone,
  input logic              noSync,
  input logic              shortBlock,
  input logic              longBlock
);
  logic              seenQ;
  logic [ADDR_W-1:0] prevAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenQ    <= 1'b0;
      prevAddr <= '0;
    end else if (memWe) begin
      seenQ    <= 1'b1;
      prevAddr <= memAddr;
    end
  end

  AST_ADDR_CONSECUTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && seenQ) |-> (memAddr == prevAddr + 1'b1)); // R1

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    sectorDone |=> !sectorDone); // R2

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    sectorDone |-> $past(memWe)); // R2

  AST_STOP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(bufferEn) && !$past(drainEn)) |-> !memWe); // R10

  AST_LOSS_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(longBlock) |-> !memWe); // R7

  AST_ENTRY_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({noSync, shortBlock, longBlock})); // R11
endmodule

bind cd_sector_framer cdf_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .bufferEn(bufferEn), .drainEn(drainEn),
  .memWe(memWe), .memAddr(memAddr), .sectorDone(sectorDone),
  .noSync(noSync), .shortBlock(shortBlock), .longBlock(longBlock)
);

// File: tb/tb_cd_sector_framer.sv
module tb_cd_sector_framer;
  localparam int SB = 2352;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inByte = '0;
  logic inErr = 1'b0;
  logic detectEn = 1'b1, interpEn = 1'b1, descrambleEn = 1'b1;
  logic bufferEn = 1'b1, drainEn = 1'b0;
  logic memWe, sectorDone, noSync, illegalSync, shortBlock, longBlock;
  logic [15:0] memAddr, sectorStart;
  logic [8:0] memData;

  int checks = 0, errors = 0;
  int writeCnt = 0, doneCnt = 0;
  int lastStart = 0;
  logic [8:0] mem [0:8191];
  logic [7:0] key [0:SB-1];

  always #10 clk = ~clk;

  cd_sector_framer dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte), .inErr(inErr),
    .detectEn(detectEn), .interpEn(interpEn), .descrambleEn(descrambleEn),
    .bufferEn(bufferEn), .drainEn(drainEn), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .sectorDone(sectorDone), .sectorStart(sectorStart),
    .noSync(noSync), .illegalSync(illegalSync), .shortBlock(shortBlock),
    .longBlock(longBlock)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (memWe) begin
        mem[memAddr[12:0]] = memData;
        writeCnt++;
      end
      if (sectorDone) begin
        doneCnt++;
        lastStart = int'(sectorStart);
      end
    end
  end

  // mode bit0: corrupt sync byte 1; mode bit1: sync pattern inside data at 100..111
  function automatic logic [7:0] rawByte(int i, int seed, int mode);
    if (i < 12) begin
      if (i == 0 || i == 11) return 8'h00;
      if ((mode & 1) != 0 && i == 1) return 8'hFE;
      return 8'hFF;
    end
    if ((mode & 2) != 0 && i >= 100 && i <= 111)
      return (i == 100 || i == 111) ? 8'h00 : 8'hFF;
    return 8'((i * 13 + seed) ^ (i >> 7));
  endfunction

  function automatic logic errBit(int i, int seed);
    return ((i + seed) % 53) == 0;
  endfunction

  function automatic logic [8:0] expWord(int i, int seed, int mode, logic descr);
    logic [7:0] b;
    b = rawByte(i, seed, mode);
    if (descr && i >= 12) b = b ^ key[i];
    return {errBit(i, seed), b};
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input logic e);
    @(negedge clk);
    inValid = 1'b1;
    inByte  = b;
    inErr   = e;
  endtask

  task automatic sendSector(input int seed, input int mode, input int n,
                            input int stopAt, input logic drainVal);
    for (int i = 0; i < n; i++) begin
      sendByte(rawByte(i, seed, mode), errBit(i, seed));
      if (i == stopAt) begin
        bufferEn = 1'b0;
        drainEn  = drainVal;
      end
    end
  endtask

  task automatic prefix();
    for (int i = 0; i < 5; i++) sendByte(8'h33, 1'b0);
  endtask

  task automatic finishStream();
    for (int i = 0; i < 11; i++) sendByte(8'h5A, 1'b0);
    @(negedge clk);
    inValid = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic doReset(input logic det, input logic itp, input logic dsc);
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    detectEn = det; interpEn = itp; descrambleEn = dsc;
    bufferEn = 1'b1; drainEn = 1'b0;
    for (int i = 0; i < 8192; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    writeCnt = 0; doneCnt = 0; lastStart = 0;
    rstN = 1'b1;
  endtask

  task automatic checkSector(input int base, input int seed, input int mode,
                             input logic descr, input string req);
    int bad = 0, firstI = -1;
    logic [8:0] a = '0, e = '0;
    for (int i = 0; i < SB; i++) begin
      if (mem[base + i] !== expWord(i, seed, mode, descr)) begin
        if (firstI < 0) begin
          firstI = i; a = mem[base + i]; e = expWord(i, seed, mode, descr);
        end
        bad++;
      end
    end
    if (bad != 0) $display("  first mismatch at byte %0d", firstI);
    check(bad == 0, req, int'(a), int'(e));
  endtask

  task automatic t_reset();
    doReset(1, 1, 1);
    @(negedge clk);
    check(memWe == 0 && sectorDone == 0, "R11 reset strobes", int'(memWe), 0);
    check({noSync, illegalSync, shortBlock, longBlock} == 4'b0, "R11 reset flags",
          int'({noSync, illegalSync, shortBlock, longBlock}), 0);
    check(sectorStart == 16'h0, "R11 reset start", int'(sectorStart), 0);
  endtask

  task automatic t_basic();
    doReset(1, 1, 1);
    prefix();
    sendSector(1, 0, SB, -1, 0);
    sendSector(2, 0, SB, -1, 0);
    finishStream();
    check(writeCnt == 2 * SB, "R1 write count", writeCnt, 2 * SB);
    check(doneCnt == 2, "R2 done count", doneCnt, 2);
    check(lastStart == SB, "R2 sector start", lastStart, SB);
    checkSector(0, 1, 0, 1, "R3 descrambled sector 0");
    checkSector(SB, 2, 0, 1, "R1 sector 1 contents");
    check({noSync, illegalSync, shortBlock, longBlock} == 4'b0, "R11 clean flags",
          int'({noSync, illegalSync, shortBlock, longBlock}), 0);
  endtask

  task automatic t_raw();
    doReset(1, 1, 0);
    prefix();
    sendSector(11, 0, SB, -1, 0);
    finishStream();
    checkSector(0, 11, 0, 0, "R3 raw sector");
  endtask

  task automatic t_insert();
    doReset(1, 1, 1);
    prefix();
    sendSector(3, 0, SB, -1, 0);
    sendSector(4, 1, SB, -1, 0);
    finishStream();
    check(writeCnt == 2 * SB, "R4 write count", writeCnt, 2 * SB);
    check(doneCnt == 2, "R4 done count", doneCnt, 2);
    check(noSync == 1, "R4 noSync", int'(noSync), 1);
    checkSector(SB, 4, 1, 1, "R4 inserted sector");
  endtask

  task automatic t_lose();
    doReset(1, 0, 1);
    prefix();
    sendSector(5, 0, SB, -1, 0);
    sendSector(6, 1, SB, -1, 0);
    finishStream();
    check(writeCnt == SB, "R7 write count", writeCnt, SB);
    check(doneCnt == 1, "R7 done count", doneCnt, 1);
    check(longBlock == 1, "R7 longBlock", int'(longBlock), 1);
  endtask

  task automatic t_illegal();
    doReset(1, 1, 1);
    prefix();
    sendSector(7, 2, SB, -1, 0);
    finishStream();
    check(writeCnt == SB, "R5 write count", writeCnt, SB);
    check(doneCnt == 1, "R5 done count", doneCnt, 1);
    check(illegalSync == 1, "R5 illegalSync", int'(illegalSync), 1);
    checkSector(0, 7, 2, 1, "R5 sector unchanged");
  endtask

  task automatic t_short();
    doReset(1, 0, 1);
    prefix();
    sendSector(8, 0, 1000, -1, 0);
    sendSector(9, 0, SB, -1, 0);
    finishStream();
    check(writeCnt == 1000 + SB, "R6 write count", writeCnt, 1000 + SB);
    check(doneCnt == 1, "R6 done count", doneCnt, 1);
    check(shortBlock == 1, "R6 shortBlock", int'(shortBlock), 1);
    check(lastStart == 1000, "R6 resync start", lastStart, 1000);
    checkSector(1000, 9, 0, 1, "R6 resynced sector");
  endtask

  task automatic t_nodetect();
    doReset(0, 1, 1);
    prefix();
    sendSector(10, 0, SB, -1, 0);
    finishStream();
    check(writeCnt == 0, "R8 no writes", writeCnt, 0);
    check(doneCnt == 0, "R8 no done", doneCnt, 0);
  endtask

  task automatic t_drain();
    doReset(1, 1, 1);
    prefix();
    sendSector(12, 0, SB, 500, 1);
    sendSector(13, 0, SB, -1, 1);
    finishStream();
    check(writeCnt == SB, "R9 write count", writeCnt, SB);
    check(doneCnt == 1, "R9 done count", doneCnt, 1);
    checkSector(0, 12, 0, 1, "R9 drained sector");
  endtask

  task automatic t_abort();
    doReset(1, 1, 1);
    prefix();
    sendSector(14, 0, SB, 500, 0);
    finishStream();
    check(writeCnt == 489, "R10 write count", writeCnt, 489);
    check(doneCnt == 0, "R10 no done", doneCnt, 0);
  endtask

  initial begin
    logic [14:0] l;
    logic [7:0] k;
    l = 15'h0001;
    for (int i = 0; i < SB; i++) key[i] = 8'h00;
    for (int i = 12; i < SB; i++) begin
      k = '0;
      for (int b = 0; b < 8; b++) begin
        k[b] = l[0];
        l = {l[0] ^ l[1], l[14:1]};
      end
      key[i] = k;
    end
    t_reset();
    t_basic();
    t_raw();
    t_insert();
    t_lose();
    t_illegal();
    t_short();
    t_nodetect();
    t_drain();
    t_abort();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule